// File: doc/BRIEF.md
# Multi-Mode Segment Address Translator

This block turns a segment index and an offset into a linear address. The result depends on a stored operating mode, which is one of four: real, 16-bit protected, 32-bit protected and 64-bit long. It holds six segment entries. Each entry has a selector, a base, a limit and a present flag. A write port loads these entries directly, so the block never walks a descriptor table. Privilege checks, paging and translation caches belong to other blocks.

A caller presents a request with a segment index and an offset. One cycle later the block returns exactly one of three outcomes: a valid linear address, a limit fault or an absence fault. The mode register is loaded through its own write strobe. Segment contents survive any mode change.

Real mode ignores the stored base, limit and present flag. It forms overlapping 64 KiB windows from the selector alone. Long mode treats the first four entries as flat. The two remaining entries still add their stored base, which suits per-thread data areas.

Top module: `seg_xlate`

## Requirements
- R1: After reset the mode is real (code 0). Every entry has selector 0, base 0, limit 0xFFFF and present set. All outputs are low until the first request.
- R2: A request accepted on a rising edge produces its result on the next edge. On that edge exactly one of `out_valid_o`, `out_lim_fault_o` and `out_abs_fault_o` is high. In a cycle with no request, all three are low. When a fault flag is high, `out_addr_o` is 0.
- R3: Real mode (code 0): the address is (selector × 16 + offset[15:0]) modulo 2^20. Base, limit and present are ignored, and no limit fault is raised.
- R4: 16-bit protected mode (code 1): only offset[15:0] is used. The address is (base + offset[15:0]) modulo 2^24.
- R5: 32-bit protected mode (code 2): only offset[31:0] is used. The address is (base + offset[31:0]) modulo 2^32.
- R6: In both protected modes, a request to an entry whose present flag is clear gives an absence fault. This takes priority over any limit fault.
- R7: In both protected modes, a used offset strictly greater than the entry's limit gives a limit fault. An offset equal to the limit translates normally.
- R8: Long mode (code 3): for entries 0 to 3 the address equals the full 64-bit offset. This holds whatever their base, limit and present flag, and no fault is raised.
- R9: Long mode: for entries 4 and 5 the address is (base + offset) modulo 2^64. The limit and present flag are ignored.
- R10: The mode register loads `mode_i` when `mode_we_i` is high. A request in that same cycle uses the old mode, and later requests use the new one. Segment entries are unchanged by mode writes.
- R11: Entry indices are 0 CS, 1 SS, 2 DS, 3 ES, 4 FS and 5 GS. A write takes effect for requests from the next cycle on. A request in the same cycle sees the old entry. Writes to indices 6 and 7 change nothing. A request to index 6 or 7 gives an absence fault in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we_i | input | 1 | Load the mode register |
| mode_i | input | 2 | New mode: 0 real, 1 prot16, 2 prot32, 3 long |
| wr_en_i | input | 1 | Load a segment entry |
| wr_idx_i | input | 3 | Entry index to load |
| wr_sel_i | input | 16 | Selector value |
| wr_base_i | input | 64 | Base value |
| wr_limit_i | input | 32 | Limit value (largest legal offset) |
| wr_present_i | input | 1 | Present flag |
| req_valid_i | input | 1 | Translation request |
| req_seg_i | input | 3 | Entry index of the request |
| req_off_i | input | 64 | Offset of the request |
| out_valid_o | output | 1 | Address is valid |
| out_lim_fault_o | output | 1 | Limit violation |
| out_abs_fault_o | output | 1 | Entry absent or index out of range |
| out_addr_o | output | 64 | Linear address, 0 on a fault |

## Verification
The bench drives offsets equal to the limit, one above it and one below it. A design with an off-by-one compare would flag the legal boundary or pass the first illegal offset. It sets absent entries with offsets past their limit, so getting the fault priority wrong shows up as a limit fault. It also sends offsets whose upper bits are set in the narrow modes, and sums that carry past the 20-, 24- and 32-bit widths. A design that dropped the truncation would report high address bits. Requests land in the same cycle as mode writes and entry writes, so a design that forwarded new state early would translate with the wrong mode or base. Long mode is exercised with absent, limited and based flat entries, and such a design would fault or add a base where none applies.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG    = 6,
  parameter int SEL_W   = 16,
  parameter int BASE_W  = 64,
  parameter int LIM_W   = 32,
  parameter int REAL_AW = 20,
  parameter int P16_AW  = 24,
  parameter int P32_AW  = 32,
  parameter int FLAT_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we_i,
  input  logic [1:0]        mode_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_idx_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  logic [LIM_W-1:0]  wr_limit_i,
  input  logic              wr_present_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_seg_i,
  input  logic [BASE_W-1:0] req_off_i,
  output logic              out_valid_o,
  output logic              out_lim_fault_o,
  output logic              out_abs_fault_o,
  output logic [BASE_W-1:0] out_addr_o
);
  localparam logic [1:0] M_REAL = 2'd0, M_P16 = 2'd1, M_P32 = 2'd2, M_LONG = 2'd3;
  localparam logic [BASE_W-1:0] ONES     = '1;
  localparam logic [BASE_W-1:0] MSK_REAL = ONES >> (BASE_W - REAL_AW);
  localparam logic [BASE_W-1:0] MSK_P16  = ONES >> (BASE_W - P16_AW);
  localparam logic [BASE_W-1:0] MSK_P32  = ONES >> (BASE_W - P32_AW);
  localparam logic [BASE_W-1:0] MSK_O16  = ONES >> (BASE_W - SEL_W);
  localparam logic [BASE_W-1:0] MSK_O32  = ONES >> (BASE_W - P32_AW);

  logic [1:0]        mode_q;
  logic [SEL_W-1:0]  sel_q  [NSEG];
  logic [BASE_W-1:0] base_q [NSEG];
  logic [LIM_W-1:0]  lim_q  [NSEG];
  logic [NSEG-1:0]   pres_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_REAL;
      pres_q <= '1;
      for (int i = 0; i < NSEG; i++) begin
        sel_q[i]  <= '0;
        base_q[i] <= '0;
        lim_q[i]  <= LIM_W'(16'hFFFF);
      end
    end else begin
      if (mode_we_i) mode_q <= mode_i;
      for (int i = 0; i < NSEG; i++) begin
        if (wr_en_i && 32'(wr_idx_i) == i) begin
          sel_q[i]  <= wr_sel_i;
          base_q[i] <= wr_base_i;
          lim_q[i]  <= wr_limit_i;
          pres_q[i] <= wr_present_i;
        end
      end
    end
  end

  logic              idx_ok, pres, flat, lim_hit, abs_hit;
  logic [SEL_W-1:0]  sel;
  logic [BASE_W-1:0] base, lim, off16, off32, addr;

  always_comb begin
    idx_ok = 32'(req_seg_i) < NSEG;
    sel  = '0;
    base = '0;
    lim  = '0;
    pres = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (32'(req_seg_i) == i) begin
        sel  = sel_q[i];
        base = base_q[i];
        lim  = BASE_W'(lim_q[i]);
        pres = pres_q[i];
      end
    end
  end

  assign off16 = req_off_i & MSK_O16;
  assign off32 = req_off_i & MSK_O32;
  assign flat  = 32'(req_seg_i) < FLAT_N;

  always_comb begin
    lim_hit = 1'b0;
    abs_hit = !idx_ok;
    addr    = '0;
    unique case (mode_q)
      M_REAL: addr = ((BASE_W'(sel) << 4) + off16) & MSK_REAL;
      M_P16: begin
        abs_hit = !idx_ok || !pres;
        lim_hit = off16 > lim;
        addr    = (base + off16) & MSK_P16;
      end
      M_P32: begin
        abs_hit = !idx_ok || !pres;
        lim_hit = off32 > lim;
        addr    = (base + off32) & MSK_P32;
      end
      default: addr = flat ? req_off_i : base + req_off_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o     <= 1'b0;
      out_lim_fault_o <= 1'b0;
      out_abs_fault_o <= 1'b0;
      out_addr_o      <= '0;
    end else begin
      out_valid_o     <= req_valid_i && !abs_hit && !lim_hit;
      out_lim_fault_o <= req_valid_i && !abs_hit && lim_hit;
      out_abs_fault_o <= req_valid_i && abs_hit;
      out_addr_o      <= (req_valid_i && !abs_hit && !lim_hit) ? addr : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int BASE_W  = 64,
  parameter int REAL_AW = 20,
  parameter int P16_AW  = 24,
  parameter int P32_AW  = 32,
  parameter int FLAT_N  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic [2:0]        req_seg_i,
  input logic [1:0]        mode_q,
  input logic              out_valid_o,
  input logic              out_lim_fault_o,
  input logic              out_abs_fault_o,
  input logic [BASE_W-1:0] out_addr_o
);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> $countones({out_valid_o, out_lim_fault_o, out_abs_fault_o}) == 1);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !(out_valid_o || out_lim_fault_o || out_abs_fault_o));

  assert_fault_addr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_lim_fault_o || out_abs_fault_o) |-> out_addr_o == '0);

  assert_real_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_q == 2'd0) |=> (!out_lim_fault_o && (out_addr_o >> REAL_AW) == '0));

  assert_p16_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_q == 2'd1) |=> (out_addr_o >> P16_AW) == '0);

  assert_p32_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_q == 2'd2) |=> (out_addr_o >> P32_AW) == '0);

  assert_long_flat_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_q == 2'd3 && 32'(req_seg_i) < FLAT_N) |=> out_valid_o);

  assert_long_based_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_q == 2'd3 && (req_seg_i == 3'd4 || req_seg_i == 3'd5)) |=> out_valid_o);

  assert_bad_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_seg_i >= 3'd6) |=> out_abs_fault_o);
endmodule

bind seg_xlate seg_xlate_chk #(
  .BASE_W(BASE_W), .REAL_AW(REAL_AW), .P16_AW(P16_AW), .P32_AW(P32_AW), .FLAT_N(FLAT_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_seg_i(req_seg_i),
  .mode_q(mode_q), .out_valid_o(out_valid_o), .out_lim_fault_o(out_lim_fault_o),
  .out_abs_fault_o(out_abs_fault_o), .out_addr_o(out_addr_o)
);

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we_i = 0;
  logic [1:0]  mode_i = 0;
  logic        wr_en_i = 0;
  logic [2:0]  wr_idx_i = 0;
  logic [15:0] wr_sel_i = 0;
  logic [63:0] wr_base_i = 0;
  logic [31:0] wr_limit_i = 0;
  logic        wr_present_i = 0;
  logic        req_valid_i = 0;
  logic [2:0]  req_seg_i = 0;
  logic [63:0] req_off_i = 0;
  logic        out_valid_o, out_lim_fault_o, out_abs_fault_o;
  logic [63:0] out_addr_o;

  always #4 clk = ~clk;

  seg_xlate dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [1:0]  m_mode;
  logic [15:0] m_sel  [6];
  logic [63:0] m_base [6];
  logic [31:0] m_lim  [6];
  logic        m_pres [6];

  bit          pend = 0;
  logic        e_v, e_l, e_a;
  logic [63:0] e_addr;
  string       e_tag;

  task automatic check(input bit ok, input string tag, input logic [66:0] act, input logic [66:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual {v,l,a,addr}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 2'd0;
    for (int i = 0; i < 6; i++) begin
      m_sel[i] = 0; m_base[i] = 0; m_lim[i] = 32'hFFFF; m_pres[i] = 1;
    end
  endtask

  task automatic expect_of(input logic [2:0] seg, input logic [63:0] off);
    logic [63:0] o;
    e_v = 0; e_l = 0; e_a = 0; e_addr = 0;
    if (seg >= 3'd6) begin e_a = 1; e_tag = "R11"; return; end
    case (m_mode)
      2'd0: begin
        e_v = 1; e_tag = "R3";
        e_addr = ((64'(m_sel[seg]) << 4) + 64'(off[15:0])) & 64'hFFFFF;
      end
      2'd1, 2'd2: begin
        o = (m_mode == 2'd1) ? 64'(off[15:0]) : 64'(off[31:0]);
        if (!m_pres[seg]) begin e_a = 1; e_tag = "R6"; end
        else if (o > 64'(m_lim[seg])) begin e_l = 1; e_tag = "R7"; end
        else begin
          e_v = 1;
          e_tag = (m_mode == 2'd1) ? "R4" : "R5";
          e_addr = (m_base[seg] + o) & ((m_mode == 2'd1) ? 64'hFFFFFF : 64'hFFFF_FFFF);
        end
      end
      default: begin
        e_v = 1;
        if (seg < 3'd4) begin e_addr = off; e_tag = "R8"; end
        else begin e_addr = m_base[seg] + off; e_tag = "R9"; end
      end
    endcase
  endtask

  task automatic step(input bit mwe, input logic [1:0] md,
                      input bit we, input logic [2:0] widx, input logic [15:0] sel,
                      input logic [63:0] base, input logic [31:0] lim, input bit pres,
                      input bit rv, input logic [2:0] seg, input logic [63:0] off,
                      input string tag);
    @(negedge clk);
    if (pend)
      check({out_valid_o, out_lim_fault_o, out_abs_fault_o, out_addr_o} == {e_v, e_l, e_a, e_addr},
            e_tag, {out_valid_o, out_lim_fault_o, out_abs_fault_o, out_addr_o}, {e_v, e_l, e_a, e_addr});
    else
      check({out_valid_o, out_lim_fault_o, out_abs_fault_o, out_addr_o} == '0,
            "R2 idle", {out_valid_o, out_lim_fault_o, out_abs_fault_o, out_addr_o}, '0);
    mode_we_i = mwe; mode_i = md;
    wr_en_i = we; wr_idx_i = widx; wr_sel_i = sel; wr_base_i = base;
    wr_limit_i = lim; wr_present_i = pres;
    req_valid_i = rv; req_seg_i = seg; req_off_i = off;
    pend = rv;
    if (rv) begin
      expect_of(seg, off);
      if (tag != "") e_tag = tag;
    end
    if (mwe) m_mode = md;
    if (we && widx < 3'd6) begin
      m_sel[widx] = sel; m_base[widx] = base; m_lim[widx] = lim; m_pres[widx] = pres;
    end
  endtask

  task automatic req(input logic [2:0] seg, input logic [63:0] off, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, seg, off, tag);
  endtask

  task automatic setmode(input logic [1:0] md);
    step(1, md, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic wseg(input logic [2:0] i, input logic [15:0] s, input logic [63:0] b,
                      input logic [31:0] l, input bit p);
    step(0, 0, 1, i, s, b, l, p, 0, 0, 0, "");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({out_valid_o, out_lim_fault_o, out_abs_fault_o, out_addr_o} == '0, "R1 outputs",
          {out_valid_o, out_lim_fault_o, out_abs_fault_o, out_addr_o}, '0);
    // R1 reset contents: real mode, zero base, limit 0xFFFF, present
    req(3'd2, 64'h1234_5678, "R1");
    setmode(2'd2);
    req(3'd0, 64'hFFFF, "R1");
    req(3'd5, 64'h10000, "R1");
    setmode(2'd0);
    // R3 wrap past 1 MiB, base/limit/present ignored
    wseg(3'd1, 16'hFFFF, 64'h5555, 32'h0, 0);
    req(3'd1, 64'hFFFF_FFFF_0000_FFF0, "R3");
    // R7 boundary in 32-bit protected mode
    wseg(3'd3, 16'h0, 64'hFFFF_FF00, 32'h1000, 1);
    setmode(2'd2);
    req(3'd3, 64'h1000, "R7");
    req(3'd3, 64'h1001, "R7");
    req(3'd3, 64'hFFFF_FFFF_0000_0FFF, "R5");
    // R6 absent beats limit
    req(3'd1, 64'hFFFF, "R6");
    // R4 offset truncation and 24-bit wrap
    setmode(2'd1);
    wseg(3'd4, 16'h0, 64'hFF_FFF0, 32'hFFFF, 1);
    req(3'd4, 64'hABCD_0020, "R4");
    // R10 same-cycle mode write uses old mode
    step(1, 2'd3, 0, 0, 0, 0, 0, 0, 1, 3'd1, 64'h10, "R10");
    req(3'd1, 64'hDEAD_BEEF_0000_0001, "R10");
    // R8 / R9 long mode
    req(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    wseg(3'd5, 16'h0, 64'hFFFF_FFFF_FFFF_FFF0, 32'h0, 0);
    req(3'd5, 64'h20, "R9");
    // R11 ignored write, bad index, same-cycle write
    wseg(3'd6, 16'h1, 64'h1, 32'h1, 0);
    req(3'd6, 64'h0, "R11");
    req(3'd7, 64'h0, "R11");
    step(0, 0, 1, 3'd4, 16'h0, 64'h100, 32'h0, 1, 1, 3'd4, 64'h1, "R11");
    req(3'd4, 64'h1, "R11");

    for (int n = 0; n < 4000; n++) begin
      bit mwe, we, rv;
      logic [2:0] s;
      logic [63:0] off;
      mwe = ($urandom % 10) == 0;
      we  = ($urandom % 4) == 0;
      rv  = ($urandom % 5) != 0;
      s   = 3'($urandom % 8);
      if ($urandom % 2) off = {$urandom, $urandom};
      else if (s < 3'd6) off = 64'(m_lim[s]) + 64'($urandom % 3) - 64'd1;
      else off = 64'($urandom);
      step(mwe, 2'($urandom), we, 3'($urandom % 8), 16'($urandom),
           {$urandom, $urandom}, ($urandom % 2) ? 32'($urandom % 32'h20000) : $urandom,
           ($urandom % 5) != 0, rv, s, off, "");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule